// File: doc/BRIEF.md
# Exception State Register Block

This block holds the processor state that describes an exception or interrupt. It has three registers:

- an exception PC register, which points back at the instruction that faulted;
- a cause register, which holds sticky pending-interrupt bits and a 4-bit exception code;
- a status register, which holds an eight-level interrupt mask and a three-deep stack of mode and enable pairs.

The surrounding core pulses an exception strobe with a code and the current PC. It pulses a return strobe when the handler finishes. It reads and writes the registers through a simple selected register port.

Five hardware interrupt lines feed the pending bits. A line latches its pending bit whether or not interrupts are enabled or masked. The bit is cleared only through an acknowledge handshake, so no request is lost while the handler runs with interrupts off.

A registered interrupt request output combines the pending bits, the mask and the current enable bit. The core samples it between instructions.

Top module: `exc_state_regs`

## Requirements
- R1: While reset is high, and on the cycle after it is released, status, cause and exception PC read as zero and `irq_o` is low. A zero status means kernel mode with interrupts disabled.
- R2: On each exception strobe, the exception PC becomes the strobe's PC minus 4, with modulo 2^32 wrap, so PC 0 gives 0xFFFFFFFC. This capture is visible after the same clock edge. An exception takes priority over a software write to the exception PC in the same cycle.
- R3: On each exception strobe, cause bits 5:2 take the 4-bit code. The code values are 0 external interrupt, 4 load or fetch address error, 5 store address error, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction and 12 overflow. Software writes to the cause register leave bits 5:2 unchanged.
- R4: Hardware line k (0 to 4) sets cause bit 11+k on any clock edge where it is high, regardless of mask or enable. The bit stays set after the line drops.
- R5: A hardware pending bit is acknowledged by writing 1 to its cause bit. It clears by the second clock edge after the acknowledge once its line is low. If the line is still high, the bit stays set and clears by the first edge after the line drops.
- R6: Cause bits 10:8 are software pending bits, loaded directly from a cause write.
- R7: Status bits 15:8 are a writable interrupt mask, and bit 8+i enables cause bit 8+i. Status bits 7:6 and 31:16, and cause bits 31:16, 7:6 and 1:0, always read 0.
- R8: Status bits 5:0 are three pairs: old in 5:4, previous in 3:2 and current in 1:0. In each pair the upper bit is user mode (1 = user) and the lower bit is interrupt enable. On an exception the bits shift left by two and the current pair becomes 00.
- R9: On a return strobe with no exception, status bits 5:0 shift right by two and the old pair stays in 5:4.
- R10: In a cycle with an exception or return strobe, a software write to status still loads the mask, but its bits 5:0 are discarded. An exception wins over a return in the same cycle.
- R11: `irq_o` is high one clock edge after the registers hold status bit 0 = 1 and at least one cause bit 8+i is set together with status bit 8+i.
- R12: The read select (0 status, 1 cause, 2 exception PC, 3 reads zero) returns the selected register's value on `rd_data_o` after one clock edge. The write select uses the same encoding, and writes to select 3 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_i | input | 1 | Exception entry strobe |
| exc_code_i | input | 4 | Exception code captured on entry |
| exc_pc_i | input | 32 | PC of the instruction after the faulting one |
| rfe_i | input | 1 | Return-from-exception strobe |
| irq_line_i | input | 5 | Hardware interrupt lines |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register write select |
| wr_data_i | input | 32 | Register write data |
| rd_sel_i | input | 2 | Register read select |
| rd_data_o | output | 32 | Registered read data |
| status_o | output | 32 | Status register value |
| cause_o | output | 32 | Cause register value |
| epc_o | output | 32 | Exception PC value |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle the properties that follow edge by edge:

- the exception PC capture and the code capture;
- the push and pop of the mode stack;
- that a hardware pending bit never drops while its line was high;
- that each line sets its bit;
- the one-edge timing of the request output and of the read port.

Only the bench scenarios can show the rest:

- the acknowledge handshake with the line held high and then released;
- that the code field ignores software writes;
- the interplay of simultaneous strobes and writes;
- the full request decode over every mask, software pending, hardware pending and enable combination.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int CODE_LSB  = 2;
  localparam int CODE_W    = 4;
  localparam int MASK_LSB  = 8;
  localparam int STACK_W   = 6;
  localparam int PAIR_W    = 2;

  typedef enum logic [CODE_W-1:0] {
    EC_EXT_IRQ   = 4'd0,
    EC_ADDR_LD   = 4'd4,
    EC_ADDR_ST   = 4'd5,
    EC_IBUS      = 4'd6,
    EC_DBUS      = 4'd7,
    EC_SYSCALL   = 4'd8,
    EC_BREAK     = 4'd9,
    EC_RSVD_INSN = 4'd10,
    EC_OVERFLOW  = 4'd12
  } exc_code_e;

endpackage

// File: rtl/exc_epc_reg.sv
module exc_epc_reg #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] epc_o
);

  localparam logic [XLEN-1:0] STEP_BACK = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] epc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q <= '0;
    end else if (exc_i) begin
      epc_q <= pc_i - STEP_BACK;
    end else if (wr_i) begin
      epc_q <= wr_data_i;
    end
  end

  assign epc_o = epc_q;

  // R2: capture points at the faulting instruction
  assert_epc_capture_R2: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> (epc_o == $past(pc_i) - STEP_BACK));

endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int HW_LINES = 5,
  parameter int SW_LINES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [HW_LINES-1:0]          lines_i,
  input  logic                         wr_i,
  input  logic [HW_LINES+SW_LINES-1:0] wr_bits_i,
  output logic [HW_LINES+SW_LINES-1:0] pend_o
);

  logic [SW_LINES-1:0] sw_q;
  logic [HW_LINES-1:0] hw_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= '0;
    end else if (wr_i) begin
      sw_q <= wr_bits_i[SW_LINES-1:0];
    end
  end

  for (genvar k = 0; k < HW_LINES; k++) begin : g_line
    logic pend_q, ack_q, pend_n, ack_n;
    always_comb begin
      pend_n = lines_i[k] | (pend_q & ~ack_q);
      ack_n  = pend_n & (ack_q | (wr_i & wr_bits_i[SW_LINES+k]));
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        ack_q  <= 1'b0;
      end else begin
        pend_q <= pend_n;
        ack_q  <= ack_n;
      end
    end
    assign hw_pend[k] = pend_q;
  end

  assign pend_o = {hw_pend, sw_q};

  // R4: a high line always leaves its pending bit set
  assert_pend_set_R4: assert property (@(posedge clk) disable iff (rst)
    (|lines_i) |=> ((hw_pend & $past(lines_i)) == $past(lines_i)));

  // R5: no pending bit drops while its line was high
  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (($past(hw_pend) & ~hw_pend & $past(lines_i)) == '0));

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
  parameter int LEVELS  = 8,
  parameter int STACK_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_i,
  input  logic               rfe_i,
  input  logic               wr_i,
  input  logic [LEVELS-1:0]  wr_mask_i,
  input  logic [STACK_W-1:0] wr_stack_i,
  output logic [LEVELS-1:0]  mask_o,
  output logic [STACK_W-1:0] stack_o
);

  localparam int PW = 2;

  logic [LEVELS-1:0]  mask_q;
  logic [STACK_W-1:0] stack_q, stack_n;

  always_comb begin
    stack_n = stack_q;
    if (exc_i) begin
      stack_n = {stack_q[STACK_W-PW-1:0], {PW{1'b0}}};
    end else if (rfe_i) begin
      stack_n = {stack_q[STACK_W-1 -: PW], stack_q[STACK_W-1:PW]};
    end else if (wr_i) begin
      stack_n = wr_stack_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else begin
      stack_q <= stack_n;
      if (wr_i) mask_q <= wr_mask_i;
    end
  end

  assign mask_o  = mask_q;
  assign stack_o = stack_q;

  // R1: reset leaves kernel mode, interrupts off, mask clear
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (stack_o == '0 && mask_o == '0));

  // R8: entry pushes the stack and clears the current pair
  assert_push_R8: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> (stack_o[PW-1:0] == '0 &&
               stack_o[STACK_W-1:PW] == $past(stack_o[STACK_W-PW-1:0])));

  // R9: return pops the stack, the old pair is kept
  assert_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (rfe_i && !exc_i) |=> (stack_o[STACK_W-PW-1:0] == $past(stack_o[STACK_W-1:PW]) &&
                           stack_o[STACK_W-1 -: PW] == $past(stack_o[STACK_W-1 -: PW])));

endmodule

// File: rtl/exc_irq_req.sv
module exc_irq_req #(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_i,
  input  logic [LEVELS-1:0] pend_i,
  input  logic [LEVELS-1:0] mask_i,
  output logic              irq_o
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ie_i & (|(pend_i & mask_i));
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_regs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int HW_LINES   = 5,
  parameter int SW_LINES   = 3,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                exc_i,
  input  logic [CODE_W-1:0]   exc_code_i,
  input  logic [XLEN-1:0]     exc_pc_i,
  input  logic                rfe_i,
  input  logic [HW_LINES-1:0] irq_line_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [XLEN-1:0]     wr_data_i,
  input  logic [1:0]          rd_sel_i,
  output logic [XLEN-1:0]     rd_data_o,
  output logic [XLEN-1:0]     status_o,
  output logic [XLEN-1:0]     cause_o,
  output logic [XLEN-1:0]     epc_o,
  output logic                irq_o
);

  localparam int LEVELS = HW_LINES + SW_LINES;

  logic               wr_status, wr_cause, wr_epc;
  logic [LEVELS-1:0]  mask, pend;
  logic [STACK_W-1:0] stack;
  logic [CODE_W-1:0]  code_q;
  logic [XLEN-1:0]    status_w, cause_w, rd_q;

  assign wr_status = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STATUS);
  assign wr_cause  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CAUSE);
  assign wr_epc    = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_EPC);

  exc_epc_reg #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .clk(clk), .rst(rst), .exc_i(exc_i), .pc_i(exc_pc_i),
    .wr_i(wr_epc), .wr_data_i(wr_data_i), .epc_o(epc_o)
  );

  exc_pending #(.HW_LINES(HW_LINES), .SW_LINES(SW_LINES)) u_pend (
    .clk(clk), .rst(rst), .lines_i(irq_line_i), .wr_i(wr_cause),
    .wr_bits_i(wr_data_i[MASK_LSB +: LEVELS]), .pend_o(pend)
  );

  exc_status_reg #(.LEVELS(LEVELS), .STACK_W(STACK_W)) u_status (
    .clk(clk), .rst(rst), .exc_i(exc_i), .rfe_i(rfe_i), .wr_i(wr_status),
    .wr_mask_i(wr_data_i[MASK_LSB +: LEVELS]), .wr_stack_i(wr_data_i[STACK_W-1:0]),
    .mask_o(mask), .stack_o(stack)
  );

  exc_irq_req #(.LEVELS(LEVELS)) u_irq (
    .clk(clk), .rst(rst), .ie_i(stack[0]), .pend_i(pend), .mask_i(mask),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)        code_q <= '0;
    else if (exc_i) code_q <= exc_code_i;
  end

  always_comb begin
    status_w = '0;
    status_w[MASK_LSB +: LEVELS] = mask;
    status_w[STACK_W-1:0]        = stack;
    cause_w = '0;
    cause_w[MASK_LSB +: LEVELS]  = pend;
    cause_w[CODE_LSB +: CODE_W]  = code_q;
  end

  assign status_o = status_w;
  assign cause_o  = cause_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (reg_sel_e'(rd_sel_i))
        SEL_STATUS: rd_q <= status_w;
        SEL_CAUSE:  rd_q <= cause_w;
        SEL_EPC:    rd_q <= epc_o;
        default:    rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;

  // R3: the exception code lands in the cause field
  assert_code_capture_R3: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> (cause_o[CODE_LSB +: CODE_W] == $past(exc_code_i)));

  // R11: request follows enable, pending and mask one edge later
  assert_irq_timing_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ($past(status_o[0]) &&
      (|($past(cause_o[MASK_LSB +: LEVELS]) & $past(status_o[MASK_LSB +: LEVELS]))))));

  // R12: reading the exception PC returns its previous-cycle value
  assert_read_epc_R12: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_e'(rd_sel_i) == SEL_EPC) |=> (rd_data_o == $past(epc_o)));

endmodule

// File: tb/exc_state_regs_tb.sv
module exc_state_regs_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        exc, rfe, wr_en;
  logic [3:0]  code;
  logic [31:0] pc, wr_data;
  logic [4:0]  lines;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] rd_data, status, cause, epc;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  exc_state_regs u_dut (
    .clk(clk), .rst(rst), .exc_i(exc), .exc_code_i(code), .exc_pc_i(pc),
    .rfe_i(rfe), .irq_line_i(lines), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .status_o(status), .cause_o(cause), .epc_o(epc), .irq_o(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_exc(input logic [3:0] c, input logic [31:0] p);
    exc = 1'b1; code = c; pc = p;
    step();
    exc = 1'b0;
  endtask

  task automatic do_rfe();
    rfe = 1'b1;
    step();
    rfe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int codes [9] = '{0, 4, 5, 6, 7, 8, 9, 10, 12};
    rst = 1'b1; exc = 0; rfe = 0; wr_en = 0; code = 0; pc = 0;
    wr_data = 0; lines = 0; wr_sel = 0; rd_sel = 0;
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", status, 32'h0);
    chk("R1 cause", cause, 32'h0);
    chk("R1 epc", epc, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2, R3 every code value, wrapping PC at zero
    for (int i = 0; i < 9; i++) begin
      logic [31:0] p;
      p = (i == 0) ? 32'h0 : 32'h1000 + 32'(i) * 32'h44;
      do_exc(4'(codes[i]), p);
      chk("R2 epc", epc, p - 32'd4);
      chk("R3 code", {28'b0, cause[5:2]}, 32'(codes[i]));
      do_rfe();
    end
    wr(2'd1, 32'h0000_003C);
    chk("R3 code unwritable", {28'b0, cause[5:2]}, 32'd12);
    chk("R7 cause zero bits", cause & 32'hFFFF_00C3, 32'h0);
    // R2 exception wins over software EPC write
    wr_en = 1; wr_sel = 2'd2; wr_data = 32'hDEAD_BEEF; exc = 1; code = 4'd8; pc = 32'h400;
    step();
    wr_en = 0; exc = 0;
    chk("R2 exc over write", epc, 32'h3FC);
    wr(2'd2, 32'hCAFE_0000);
    chk("R2 sw epc write", epc, 32'hCAFE_0000);
    do_rfe();

    // R7 mask and zero fields
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R7 status fields", status, 32'h0000_FF3F);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R12 select 3 write ignored", status, 32'h0000_FF3F);

    // R8, R9 over all stack values
    for (int s = 0; s < 64; s++) begin
      wr(2'd0, 32'(s));
      do_exc(4'd9, 32'h100);
      chk("R8 push", status & 32'h3F, 32'((s << 2) & 6'h3C));
      do_rfe();
      chk("R9 pop after push", status & 32'h3F, 32'((((s >> 2) & 3) << 4) | (s & 15)));
      wr(2'd0, 32'(s));
      do_rfe();
      chk("R9 pop", status & 32'h3F, 32'((s & 6'h30) | (s >> 2)));
    end

    // R10 strobes override software stack write, mask still taken
    wr(2'd0, 32'h0000_0027);
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'h0000_A53F; exc = 1; rfe = 1; code = 4'd4; pc = 32'h20;
    step();
    wr_en = 0; exc = 0; rfe = 0;
    chk("R10 exc wins", status, 32'h0000_A51C);
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'h0000_5A00; rfe = 1;
    step();
    wr_en = 0; rfe = 0;
    chk("R10 rfe over write", status, 32'h0000_5A17);

    // R4 pending while disabled and masked
    wr(2'd0, 32'h0);
    for (int k = 0; k < 5; k++) begin
      lines = 5'(1 << k);
      step();
      lines = 0;
      repeat (3) step();
      chk("R4 sticky", cause & 32'h0000_FF00, 32'(1 << (11 + k)));
      chk("R4 no irq when disabled", {31'b0, irq}, 32'h0);
      // R5 acknowledge with line low
      wr(2'd1, 32'(1 << (11 + k)));
      chk("R5 held one edge", cause & 32'h0000_F800, 32'(1 << (11 + k)));
      step();
      chk("R5 cleared", cause & 32'h0000_F800, 32'h0);
    end
    // R5 acknowledge with line still high
    lines = 5'b00100;
    step();
    wr(2'd1, 32'h0000_2000);
    repeat (3) step();
    chk("R5 held while high", cause & 32'h0000_F800, 32'h0000_2000);
    lines = 0;
    step();
    chk("R5 clears after drop", cause & 32'h0000_F800, 32'h0);

    // R6 software pending bits
    wr(2'd1, 32'h0000_0700);
    chk("R6 sw pend all", cause & 32'h0000_FF00, 32'h0000_0700);
    wr(2'd1, 32'h0000_0100);
    chk("R6 sw pend one", cause & 32'h0000_FF00, 32'h0000_0100);

    // R11 sweep over software pending, mask and enable
    for (int m = 0; m < 256; m++) begin
      for (int s = 0; s < 8; s++) begin
        for (int e = 0; e < 2; e++) begin
          wr(2'd1, 32'(s << 8));
          wr(2'd0, 32'((m << 8) | e));
          step();
          chk("R11 sw sweep", {31'b0, irq}, 32'((e == 1) && ((s & m & 7) != 0)));
        end
      end
    end
    wr(2'd1, 32'h0);

    // R11 sweep over hardware pending and mask
    for (int p = 1; p < 32; p++) begin
      lines = 5'(p);
      step();
      lines = 0;
      step();
      chk("R4 pattern", cause & 32'h0000_FF00, 32'(p << 11));
      for (int m = 0; m < 256; m++) begin
        wr(2'd0, 32'((m << 8) | 1));
        step();
        chk("R11 hw sweep", {31'b0, irq}, 32'((p & (m >> 3)) != 0));
      end
      wr(2'd1, 32'(p << 11));
      step();
      chk("R5 bulk clear", cause & 32'h0000_F800, 32'h0);
    end

    // R12 read port
    wr(2'd0, 32'h0000_1234);
    wr(2'd2, 32'h8765_4320);
    wr(2'd1, 32'h0000_0500);
    for (int r = 0; r < 4; r++) begin
      logic [31:0] exp;
      rd_sel = 2'(r);
      step();
      case (r)
        0: exp = 32'h0000_1234;
        1: exp = 32'h0000_0500 | (32'd4 << 2);
        2: exp = 32'h8765_4320;
        default: exp = 32'h0;
      endcase
      chk("R12 read", rd_data, exp);
    end

    // R1 reset again from a busy state
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 status after reset", status, 32'h0);
    chk("R1 cause after reset", cause, 32'h0);
    chk("R1 epc after reset", epc, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule